// File: doc/BRIEF.md
# Grouped-Word ECC Memory

This block is an on-chip word store. It keeps 32-bit words in groups of four. Each group is held as a single 128-bit protected unit that shares one 8-bit Hamming check field. A host reads or writes single words through a word-addressed request port with a valid/ready handshake. Each read is answered with the data word and two status flags.

Every access first reads the addressed storage row and decodes the selected group. A read returns the requested word after any single-bit fault in the group's 136 stored bits has been repaired. When a repair was needed, the repaired group is written back into the array. A write merges the new word into the decoded group, recomputes the shared check field and writes the row back. A write therefore always costs a read of the three other words of its group.

Each storage row interleaves two groups bit by bit, so two upsets in neighbouring cells land in different groups. A test input flips any single stored bit. This lets faults be placed at known physical columns.

Top module: `mwecc_mem`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1 and `rsp_valid`, `rsp_corrected` and `rsp_uncorr` are 0.
- R2: A read accepted at clock edge N raises `rsp_valid` for exactly the one cycle that follows edge N+1. In that cycle `rsp_rdata` holds the word most recently written to that address.
- R3: A write accepted at edge N holds `req_ready` low after edges N and N+1 and raises it again after edge N+2. A read with no repair holds it low only after edge N.
- R4: Address bits [1:0] pick the word in a group, bit [2] picks one of the two groups in a row, and the upper bits pick the row. Writing one word leaves the other seven words of its row unchanged.
- R5: A read of a group holding one flipped bit returns the correct word with `rsp_corrected` = 1. This holds for a fault in any data bit of any of the four words and for a fault in a check bit.
- R6: A repairing read writes the repaired group back. `req_ready` stays low one extra cycle, and the next read of that group reports no flag.
- R7: Physical column c of a row holds bit c>>1 of the group selected by c[0]. Flipping two adjacent columns leaves one fault in each group, and each fault is repaired.
- R8: A syndrome above 136 raises `rsp_uncorr` with `rsp_corrected` = 0. The word is returned unrepaired, nothing is written back, and the flag repeats on a later read.
- R9: A write into a group that holds one flipped bit stores the repaired sibling words, so a later read of those words raises no flag.
- R10: Group bit i < 128 is data bit i, with word w at bits 32w+31..32w. Bits 128..135 are check bits 0..7. Check bit k sits at Hamming position 2^k. Data bits take the other positions in ascending order starting at 3, so a fault pair on check bits 7 and 4 gives syndrome 144.
- R11: `rsp_corrected` and `rsp_uncorr` are never 1 together, and neither is 1 unless `rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Word address {row, group select, word select} |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present (one cycle) |
| rsp_rdata | output | 32 | Read data |
| rsp_corrected | output | 1 | A single fault was repaired on this read |
| rsp_uncorr | output | 1 | Syndrome outside the code; data not repaired |
| flip_en | input | 1 | Invert one stored bit at the next edge |
| flip_row | input | 3 | Row of the bit to invert |
| flip_col | input | 9 | Physical column of the bit to invert |

## Verification
A read response is due in the cycle after the second clock edge counted from the accepting edge. `req_ready` comes back one edge later for a plain read, or two edges later for a write or a repairing read. Every result in this block is tied to one of these edge counts. The bench records the edge at which each request is accepted. It then samples outputs at the falling edge of exactly those cycles, and at every falling edge it compares `rsp_valid` with its own record of when a response is due. Faults are injected only while the port is idle, so the expected flags depend only on the injected columns and the code layout stated in the requirements.

// File: rtl/mwecc_pkg.sv
`timescale 1ns/1ps
package mwecc_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WB} mw_state_e;

  function automatic bit hm_is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // smallest r with 2^r >= n + r + 1
  function automatic int hm_chk_width(input int n);
    int res;
    res = 0;
    for (int r = 1; r < 31; r++)
      if (res == 0 && (1 << r) >= n + r + 1) res = r;
    return res;
  endfunction

  // Hamming position of data bit j (non power-of-two positions from 3 upward)
  function automatic int hm_data_pos(input int j, input int n);
    int cnt;
    int res;
    int lim;
    cnt = 0;
    res = 0;
    lim = n + hm_chk_width(n);
    for (int p = 3; p <= lim; p++) begin
      if (!hm_is_pow2(p)) begin
        if (cnt == j) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/mwecc_enc.sv
`timescale 1ns/1ps
module mwecc_enc
  import mwecc_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CHK_W  = hm_chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  localparam int GROUPS = (DATA_W + 3) / 4;
  localparam int LVLS   = ($clog2(DATA_W) + 1) / 2;

  logic [CHK_W-1:0][DATA_W-1:0] sel_mask;

  for (genvar j = 0; j < DATA_W; j++) begin : g_pos
    localparam logic [31:0] POSV = 32'(hm_data_pos(j, DATA_W));
    for (genvar k = 0; k < CHK_W; k++) begin : g_bit
      assign sel_mask[k][j] = POSV[k];
    end
  end

  // parity built as a tree of 4-input XOR stages
  function automatic logic xor4_reduce(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] t;
    logic [DATA_W-1:0] nt;
    t = v;
    for (int lvl = 0; lvl < LVLS; lvl++) begin
      nt = '0;
      for (int i = 0; i < GROUPS; i++)
        for (int b = 0; b < 4; b++)
          if (4 * i + b < DATA_W) nt[i] = nt[i] ^ t[4 * i + b];
      t = nt;
    end
    return t[0];
  endfunction

  always_comb begin
    for (int k = 0; k < CHK_W; k++) chk_o[k] = xor4_reduce(data_i & sel_mask[k]);
  end
endmodule

// File: rtl/mwecc_dec.sv
`timescale 1ns/1ps
module mwecc_dec
  import mwecc_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CHK_W  = hm_chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o,
  output logic              bad_o
);
  localparam int CW_N = DATA_W + CHK_W;

  logic [CHK_W-1:0]  recomp;
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] fix;

  mwecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (data_i),
    .chk_o  (recomp)
  );

  assign syn = recomp ^ chk_i;

  for (genvar j = 0; j < DATA_W; j++) begin : g_fix
    localparam logic [CHK_W-1:0] POSV = CHK_W'(hm_data_pos(j, DATA_W));
    assign fix[j] = (syn == POSV);
  end

  assign err_o  = (syn != '0);
  assign bad_o  = (int'(syn) > CW_N);
  assign data_o = bad_o ? data_i : (data_i ^ fix);
endmodule

// File: rtl/mwecc_array.sv
`timescale 1ns/1ps
module mwecc_array #(
  parameter int ROWS  = 8,
  parameter int ROW_W = 272,
  localparam int RA_W  = $clog2(ROWS),
  localparam int COL_W = $clog2(ROW_W)
) (
  input  logic             clk,
  input  logic             rd_en,
  input  logic [RA_W-1:0]  rd_row,
  output logic [ROW_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [RA_W-1:0]  wr_row,
  input  logic [ROW_W-1:0] wr_data,
  input  logic             flip_en,
  input  logic [RA_W-1:0]  flip_row,
  input  logic [COL_W-1:0] flip_col
);
  logic [ROW_W-1:0] mem [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) mem[r] = '0;
    rd_data = '0;
  end

  // one read port, one full-row write port
  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_row];
    if (wr_en) mem[wr_row] <= wr_data;
    if (flip_en) mem[flip_row][flip_col] <= ~mem[flip_row][flip_col];
  end
endmodule

// File: rtl/mwecc_mem.sv
`timescale 1ns/1ps
module mwecc_mem
  import mwecc_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int INTLV  = 2,
  parameter int ROW_AW = 3,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int ISEL_W = $clog2(INTLV),
  localparam int ADDR_W = ROW_AW + ISEL_W + WSEL_W,
  localparam int DATA_W = WORD_W * WORDS,
  localparam int CHK_W  = hm_chk_width(DATA_W),
  localparam int CW_N   = DATA_W + CHK_W,
  localparam int ROW_W  = CW_N * INTLV,
  localparam int COL_W  = $clog2(ROW_W),
  localparam int ROWS   = 1 << ROW_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_corrected,
  output logic              rsp_uncorr,
  input  logic              flip_en,
  input  logic [ROW_AW-1:0] flip_row,
  input  logic [COL_W-1:0]  flip_col
);
  mw_state_e state;

  logic              lat_we;
  logic [WSEL_W-1:0] lat_word;
  logic [ISEL_W-1:0] lat_sel;
  logic [ROW_AW-1:0] lat_row;
  logic [WORD_W-1:0] lat_wdata;

  logic [ROW_W-1:0]  row_rd;
  logic [ROW_W-1:0]  row_wr;
  logic [INTLV-1:0][CW_N-1:0] cw_rd;
  logic [CW_N-1:0]   cw_sel;
  logic [DATA_W-1:0] dec_data;
  logic              dec_err;
  logic              dec_bad;
  logic              fixable;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] wb_data;
  logic [CHK_W-1:0]  wb_chk;
  logic [CW_N-1:0]   wb_cw;
  logic              accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  mwecc_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
    .clk      (clk),
    .rd_en    (accept),
    .rd_row   (req_addr[ADDR_W-1 -: ROW_AW]),
    .rd_data  (row_rd),
    .wr_en    (state == ST_WB),
    .wr_row   (lat_row),
    .wr_data  (row_wr),
    .flip_en  (flip_en),
    .flip_row (flip_row),
    .flip_col (flip_col)
  );

  // bit-interleaved row <-> composite groups
  for (genvar s = 0; s < INTLV; s++) begin : g_lane
    for (genvar i = 0; i < CW_N; i++) begin : g_bit
      assign cw_rd[s][i] = row_rd[i * INTLV + s];
      assign row_wr[i * INTLV + s] = (lat_sel == ISEL_W'(s)) ? wb_cw[i] : row_rd[i * INTLV + s];
    end
  end

  assign cw_sel = cw_rd[lat_sel];

  mwecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .data_i (cw_sel[DATA_W-1:0]),
    .chk_i  (cw_sel[CW_N-1:DATA_W]),
    .data_o (dec_data),
    .err_o  (dec_err),
    .bad_o  (dec_bad)
  );

  assign fixable = dec_err && !dec_bad;

  always_comb begin
    merged = dec_data;
    merged[lat_word * WORD_W +: WORD_W] = lat_wdata;
  end

  mwecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
    .data_i (wb_data),
    .chk_o  (wb_chk)
  );

  assign wb_cw = {wb_chk, wb_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      lat_we        <= 1'b0;
      lat_word      <= '0;
      lat_sel       <= '0;
      lat_row       <= '0;
      lat_wdata     <= '0;
      wb_data       <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_corrected <= 1'b0;
      rsp_uncorr    <= 1'b0;
    end else begin
      rsp_valid     <= 1'b0;
      rsp_corrected <= 1'b0;
      rsp_uncorr    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            lat_we    <= req_we;
            lat_word  <= req_addr[WSEL_W-1:0];
            lat_sel   <= req_addr[WSEL_W +: ISEL_W];
            lat_row   <= req_addr[ADDR_W-1 -: ROW_AW];
            lat_wdata <= req_wdata;
            state     <= ST_RD;
          end
        end
        ST_RD: begin
          if (lat_we) begin
            wb_data <= merged;
            state   <= ST_WB;
          end else begin
            rsp_valid     <= 1'b1;
            rsp_rdata     <= dec_data[lat_word * WORD_W +: WORD_W];
            rsp_corrected <= fixable;
            rsp_uncorr    <= dec_bad;
            if (fixable) begin
              wb_data <= dec_data;
              state   <= ST_WB;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WB:   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_accept_busy_r3: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  p_wb_after_rd_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |-> ($past(state) == ST_RD));

  p_rsp_single_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_flag_with_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    (rsp_corrected || rsp_uncorr) |-> rsp_valid);

  p_flag_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(rsp_corrected && rsp_uncorr));

  p_scrub_busy_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_corrected |-> !req_ready);

  p_uncorr_no_scrub_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_uncorr |-> req_ready);

  p_flip_col_r7: assert property (@(posedge clk) disable iff (rst)
    flip_en |-> (int'(flip_col) < ROW_W));
endmodule

// File: tb/test_mwecc_mem.sv
`timescale 1ns/1ps
module test_mwecc_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_corrected;
  logic        rsp_uncorr;
  logic        flip_en = 1'b0;
  logic [2:0]  flip_row = '0;
  logic [8:0]  flip_col = '0;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int exp_rsp_cyc = -10;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  logic [31:0] model [64];
  int          kind  [16];  // 0 clean, 1 one fault, 2 syndrome beyond code

  mwecc_mem i_mwecc_mem (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_corrected(rsp_corrected), .rsp_uncorr(rsp_uncorr),
    .flip_en(flip_en), .flip_row(flip_row), .flip_col(flip_col)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R2: response strobe compared with the bench's schedule on every clock
  always @(negedge clk) begin
    if (mon_on) chk("R2 rsp_valid schedule", rsp_valid, (cyc == exp_rsp_cyc));
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input int a, input logic [31:0] d);
    int n;
    wait_idle();
    req_valid = 1'b1; req_we = 1'b1; req_addr = 6'(a); req_wdata = d;
    @(posedge clk); #1 n = cyc;
    @(negedge clk); req_valid = 1'b0; req_we = 1'b0;
    chk("R3 ready low after accept", req_ready, 1'b0);
    @(negedge clk); chk("R3 ready low during merge", req_ready, 1'b0);
    @(negedge clk); chk("R3 ready back after writeback", req_ready, 1'b1);
    model[a] = d;
    kind[a >> 2] = 0;
    if (cyc != n + 2) chk("R3 write timing", 64'(cyc), 64'(n + 2));
  endtask

  task automatic do_read(input int a, input string req);
    int n;
    int ek;
    ek = kind[a >> 2];
    wait_idle();
    req_valid = 1'b1; req_we = 1'b0; req_addr = 6'(a);
    @(posedge clk); #1 n = cyc; exp_rsp_cyc = n + 1;
    @(negedge clk); req_valid = 1'b0;
    chk({req, " busy after accept"}, req_ready, 1'b0);
    @(negedge clk);
    chk({req, " data"}, rsp_rdata, model[a]);
    chk({req, " corrected flag"}, rsp_corrected, (ek == 1));
    chk({req, " uncorrectable flag"}, rsp_uncorr, (ek == 2));
    chk({req, " ready with response"}, req_ready, (ek != 1));
    @(negedge clk); chk({req, " ready afterwards"}, req_ready, 1'b1);
    if (ek == 1) kind[a >> 2] = 0;
  endtask

  task automatic do_flip(input int row, input int col);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    flip_en = 1'b1; flip_row = 3'(row); flip_col = 9'(col);
    @(negedge clk); flip_en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 32'(i + 1) * 32'h9E3779B1;
    for (int i = 0; i < 16; i++) kind[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1'b1);
    chk("R1 rsp_valid in reset", rsp_valid, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1'b1);
    chk("R1 rsp_valid after reset", rsp_valid, 1'b0);
    chk("R1 flags after reset", {rsp_corrected, rsp_uncorr}, 2'b00);
    mon_on = 1'b1;

    // R2/R3: fill every address, then read all back
    for (int a = 0; a < 64; a++) do_write(a, model[a]);
    for (int a = 0; a < 64; a++) do_read(a, "R2 read back");

    // R4: one write leaves the other seven words of the row intact
    do_write(6'h2D, 32'hC0FFEE11);
    do_read(6'h2D, "R4 written word");
    do_read(6'h2C, "R4 sibling word0");
    do_read(6'h2E, "R4 sibling word2");
    do_read(6'h2F, "R4 sibling word3");
    do_read(6'h29, "R4 other group word1");
    do_read(6'h2A, "R4 other group word2");

    // R5/R6: single faults; column = 2*bit + group select (R7 layout)
    do_flip(1, 0);               kind[2] = 1;   // row1 grp0 data bit0
    do_read(6'h08 + 0, "R5 data bit0");
    do_read(6'h08 + 0, "R6 after scrub");
    do_flip(1, 2 * 127 + 1);     kind[3] = 1;   // row1 grp1 data bit127
    do_read(6'h0F, "R5 data bit127");
    do_read(6'h0F, "R6 after scrub bit127");
    do_flip(6, 2 * 131);         kind[12] = 1;  // row6 grp0 check bit3
    do_read(6'h30, "R5 check bit3");
    do_read(6'h30, "R6 after scrub check");
    do_flip(0, 2 * 45 + 1);      kind[1] = 1;   // row0 grp1 bit45 (word1)
    do_read(6'h07, "R5 fault in other word");
    do_read(6'h05, "R6 faulted word after scrub");

    // R7: adjacent physical columns fall into different groups
    do_flip(5, 80);  kind[10] = 1;
    do_flip(5, 81);  kind[11] = 1;
    do_read(6'h29, "R7 group0 word1");
    do_read(6'h2D, "R7 group1 word1");

    // R8/R10: check bits 7 and 4 flipped -> syndrome 144
    do_flip(2, 2 * 135 + 1);
    do_flip(2, 2 * 132 + 1);     kind[5] = 2;
    do_read(6'h16, "R8 uncorrectable");
    do_read(6'h16, "R8 flag repeats without writeback");
    do_write(6'h15, 32'h13572468);
    do_read(6'h16, "R8 group clean after write");
    do_read(6'h15, "R8 new word");

    // R9: a write repairs a faulted sibling
    do_flip(3, 2 * 70);          kind[6] = 1;   // row3 grp0 bit70 (word2)
    do_write(6'h18, 32'hA5A5F00D);
    do_read(6'h1A, "R9 sibling repaired by write");
    do_read(6'h18, "R9 written word");

    @(negedge clk);
    mon_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule